// File: doc/BRIEF.md
# BCD Calendar Counter with Alarm

This block keeps time of day and a running day count for a system that supplies a one-second tick. Seconds, minutes and hours are held in BCD; the date is a plain 15-bit binary day number that software converts to a calendar date. Each accepted tick advances the seconds, and the rollovers ripple into the minutes, the hours and the day count.

A minute-resolution alarm compares minute, hour and day values against the time just reached whenever the seconds roll over to 00. Each of the three fields has its own compare enable. A match sets a sticky flag, and the interrupt output follows that flag when the alarm interrupt enable is set. Registers sit behind an 8-bit address and 8-bit data port. Reads are combinational. A write that lands in the same cycle as a tick update is held for one cycle and then applied, so neither the tick nor the write is lost. The host must leave at least one idle cycle between writes, and ticks must be at least two cycles apart.

Top module: `bcd_calendar`

## Requirements
- R1: Seconds (address 0x15, 7 bits, BCD) count 00 to 59 on each accepted tick, wrap to 00 and carry one step into the minutes.
- R2: Minutes (0x16, 7 bits) count 00 to 59 and carry into hours; hours (0x17, 6 bits) count 00 to 23 and carry into the day count.
- R3: The day count is 15-bit binary, low byte at 0x18 and high 7 bits at 0x19 (bit 7 reads 0). It carries from the low byte into the high byte and wraps from 0x7FFF to 0.
- R4: Alarm minute (0x1A, 7 bits), alarm hour (0x1B, 6 bits), alarm day low (0x1C) and alarm day high (0x1D, 7 bits) read back what was written. Time registers written with valid BCD read back the written value.
- R5: Control at 0x14 reads {busy, 0, day_en, hour_en, min_en, alarm_flag, irq_en, count_en} from bit 7 down to bit 0. Bit 6 and bit 7 ignore writes.
- R6: While count_en is 0, ticks are ignored: no field changes and busy stays 0.
- R7: Busy (control bit 7) is 1 exactly in the cycle where tick_i is high and count_en is 1. That is the cycle whose clock edge applies the update.
- R8: A write presented while busy is 1 is held and applied at the following clock edge. Both the tick update and the written value take effect, and the written value is the one that remains.
- R9: The alarm flag is set at the tick where seconds roll to 00 and every enabled field (minute, hour, day) equals the newly reached value. Seconds are never compared. With no field enabled, the flag sets at every minute rollover.
- R10: Writing 1 to control bit 2 clears the alarm flag; writing 0 there leaves it unchanged. A clear held behind a flag-setting tick takes effect one cycle after the flag sets.
- R11: irq_o is high when the alarm flag and irq_en are both 1, and low otherwise.
- R12: After reset all registers read 0 and irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-second tick, one cycle wide |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register address for reads and writes |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i, combinational |
| irq_o | output | 1 | Alarm interrupt |

## Verification
Two functions can fall in the same cycle: a tick update and a host write. The bench drives tick_i and we_i high together at a seconds write, and checks that the tick increment appears after the first edge and the written value after the second. It repeats the collision with a flag-clearing control write at a matching minute rollover, and expects the flag and interrupt to rise for one cycle and then drop. A behavioural model compares the addressed read data and the interrupt with the design on every clock.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 8;
  localparam int NUM_TF = 3;  // sec, min, hour

  localparam logic [ADDR_W-1:0] A_CTRL  = 8'h14;
  localparam logic [ADDR_W-1:0] A_SEC   = 8'h15;
  localparam logic [ADDR_W-1:0] A_MIN   = 8'h16;
  localparam logic [ADDR_W-1:0] A_HOUR  = 8'h17;
  localparam logic [ADDR_W-1:0] A_DAYL  = 8'h18;
  localparam logic [ADDR_W-1:0] A_DAYH  = 8'h19;
  localparam logic [ADDR_W-1:0] A_AMIN  = 8'h1A;
  localparam logic [ADDR_W-1:0] A_AHOUR = 8'h1B;
  localparam logic [ADDR_W-1:0] A_ADAYL = 8'h1C;
  localparam logic [ADDR_W-1:0] A_ADAYH = 8'h1D;

  localparam int B_BUSY  = 7;
  localparam int B_DEN   = 5;
  localparam int B_HEN   = 4;
  localparam int B_MEN   = 3;
  localparam int B_FLAG  = 2;
  localparam int B_IEN   = 1;
  localparam int B_CEN   = 0;

  function automatic int tf_width(input int idx);
    return (idx == 2) ? 6 : 7;
  endfunction

  function automatic int tf_max(input int idx);
    return (idx == 2) ? 'h23 : 'h59;
  endfunction
endpackage

// File: rtl/cal_bcd_field.sv
module cal_bcd_field #(
  parameter int W   = 7,
  parameter int MAX = 'h59
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] val_o,
  output logic [W-1:0] nxt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] MAX_V = W'(MAX);
  localparam int HI_W = W - 4;

  logic [W-1:0]    val_q, inc_val, d;
  logic [3:0]      lo;
  logic [HI_W-1:0] hi;

  assign lo = val_q[3:0];
  assign hi = val_q[W-1:4];

  always_comb begin
    if (val_q == MAX_V)  inc_val = '0;
    else if (lo == 4'd9) inc_val = {hi + HI_W'(1), 4'd0};
    else                 inc_val = {hi, lo + 4'd1};
  end

  always_comb begin
    d = val_q;
    if (load_i)      d = load_val_i;
    else if (step_i) d = inc_val;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) val_q <= '0;
    else         val_q <= d;
  end

  assign val_o  = val_q;
  assign nxt_o  = d;
  assign wrap_o = step_i && (val_q == MAX_V);

  // R1 / R2: field returns to zero after its top value
  a_r1_field_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_i && val_q == MAX_V |=> val_q == '0);
endmodule

// File: rtl/cal_day_counter.sv
module cal_day_counter #(
  parameter int DAY_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             load_lo_i,
  input  logic             load_hi_i,
  input  logic [7:0]       data_i,
  output logic [DAY_W-1:0] val_o,
  output logic [DAY_W-1:0] nxt_o
);
  localparam int HI_W = DAY_W - 8;
  localparam logic [DAY_W-1:0] DAY_MAX = {DAY_W{1'b1}};

  logic [DAY_W-1:0] day_q, d;

  always_comb begin
    d = day_q;
    if (load_lo_i)      d = {day_q[DAY_W-1:8], data_i};
    else if (load_hi_i) d = {data_i[HI_W-1:0], day_q[7:0]};
    else if (step_i)    d = (day_q == DAY_MAX) ? '0 : day_q + DAY_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) day_q <= '0;
    else         day_q <= d;
  end

  assign val_o = day_q;
  assign nxt_o = d;

  a_r3_day_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !load_lo_i && !load_hi_i && day_q == DAY_MAX |=> day_q == '0);
endmodule

// File: rtl/cal_alarm.sv
module cal_alarm #(
  parameter int DAY_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             roll_i,
  input  logic [6:0]       min_nxt_i,
  input  logic [5:0]       hour_nxt_i,
  input  logic [DAY_W-1:0] day_nxt_i,
  input  logic [6:0]       amin_i,
  input  logic [5:0]       ahour_i,
  input  logic [DAY_W-1:0] aday_i,
  input  logic [2:0]       en_i,    // {day, hour, min}
  input  logic             clr_i,
  output logic             flag_o
);
  logic [2:0] hit;
  logic       set, flag_q;

  // a disabled field counts as a hit
  assign hit[0] = !en_i[0] || (min_nxt_i  == amin_i);
  assign hit[1] = !en_i[1] || (hour_nxt_i == ahour_i);
  assign hit[2] = !en_i[2] || (day_nxt_i  == aday_i);
  assign set    = roll_i && (&hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (set)    flag_q <= 1'b1;
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;

  a_r9_rise_on_roll: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(roll_i));
  a_r10_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !roll_i |=> !flag_q);
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
#(
  parameter int DAY_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int HI_W = DAY_W - 8;

  logic              cen_q, ien_q;
  logic [2:0]        fen_q;  // {day, hour, min}
  logic [6:0]        amin_q;
  logic [5:0]        ahour_q;
  logic [DAY_W-1:0]  aday_q;
  logic              busy;

  logic              hold_v_q;
  logic [ADDR_W-1:0] hold_addr_q;
  logic [DATA_W-1:0] hold_data_q;
  logic              apply_v;
  logic [ADDR_W-1:0] apply_addr;
  logic [DATA_W-1:0] apply_data;

  logic [DATA_W-1:0] tf_q   [NUM_TF];
  logic [DATA_W-1:0] tf_nxt [NUM_TF];
  logic [NUM_TF:0]   step;
  logic [DAY_W-1:0]  day_q, day_nxt;
  logic              flag;

  assign busy = tick_i && cen_q;

  // write path: writes that meet a tick update wait one cycle
  assign apply_v    = !busy && (hold_v_q || we_i);
  assign apply_addr = hold_v_q ? hold_addr_q : addr_i;
  assign apply_data = hold_v_q ? hold_data_q : wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_v_q    <= 1'b0;
      hold_addr_q <= '0;
      hold_data_q <= '0;
    end else if (busy && we_i) begin
      hold_v_q    <= 1'b1;
      hold_addr_q <= addr_i;
      hold_data_q <= wdata_i;
    end else if (!busy) begin
      hold_v_q    <= 1'b0;
    end
  end

  function automatic logic wr_to(input logic [ADDR_W-1:0] a);
    return apply_v && (apply_addr == a);
  endfunction

  // time-of-day chain
  assign step[0] = busy;

  for (genvar i = 0; i < NUM_TF; i++) begin : g_tf
    localparam int FW = tf_width(i);
    logic [FW-1:0] v, n;
    logic          w;

    cal_bcd_field #(.W(FW), .MAX(tf_max(i))) i_field (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .step_i     (step[i]),
      .load_i     (wr_to(A_SEC + ADDR_W'(i))),
      .load_val_i (apply_data[FW-1:0]),
      .val_o      (v),
      .nxt_o      (n),
      .wrap_o     (w)
    );

    assign tf_q[i]   = DATA_W'(v);
    assign tf_nxt[i] = DATA_W'(n);
    assign step[i+1] = w;
  end

  cal_day_counter #(.DAY_W(DAY_W)) i_day (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (step[NUM_TF]),
    .load_lo_i (wr_to(A_DAYL)),
    .load_hi_i (wr_to(A_DAYH)),
    .data_i    (apply_data),
    .val_o     (day_q),
    .nxt_o     (day_nxt)
  );

  // control and alarm compare registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cen_q   <= 1'b0;
      ien_q   <= 1'b0;
      fen_q   <= '0;
      amin_q  <= '0;
      ahour_q <= '0;
      aday_q  <= '0;
    end else begin
      if (wr_to(A_CTRL)) begin
        cen_q <= apply_data[B_CEN];
        ien_q <= apply_data[B_IEN];
        fen_q <= {apply_data[B_DEN], apply_data[B_HEN], apply_data[B_MEN]};
      end
      if (wr_to(A_AMIN))  amin_q  <= apply_data[6:0];
      if (wr_to(A_AHOUR)) ahour_q <= apply_data[5:0];
      if (wr_to(A_ADAYL)) aday_q  <= {aday_q[DAY_W-1:8], apply_data};
      if (wr_to(A_ADAYH)) aday_q  <= {apply_data[HI_W-1:0], aday_q[7:0]};
    end
  end

  cal_alarm #(.DAY_W(DAY_W)) i_alarm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .roll_i     (step[1]),
    .min_nxt_i  (tf_nxt[1][6:0]),
    .hour_nxt_i (tf_nxt[2][5:0]),
    .day_nxt_i  (day_nxt),
    .amin_i     (amin_q),
    .ahour_i    (ahour_q),
    .aday_i     (aday_q),
    .en_i       (fen_q),
    .clr_i      (wr_to(A_CTRL) && apply_data[B_FLAG]),
    .flag_o     (flag)
  );

  assign irq_o = flag && ien_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_CTRL:  rdata_o = {busy, 1'b0, fen_q[2], fen_q[1], fen_q[0], flag, ien_q, cen_q};
      A_SEC:   rdata_o = tf_q[0];
      A_MIN:   rdata_o = tf_q[1];
      A_HOUR:  rdata_o = tf_q[2];
      A_DAYL:  rdata_o = day_q[7:0];
      A_DAYH:  rdata_o = DATA_W'(day_q[DAY_W-1:8]);
      A_AMIN:  rdata_o = DATA_W'(amin_q);
      A_AHOUR: rdata_o = DATA_W'(ahour_q);
      A_ADAYL: rdata_o = aday_q[7:0];
      A_ADAYH: rdata_o = DATA_W'(aday_q[DAY_W-1:8]);
      default: rdata_o = '0;
    endcase
  end

  a_r8_hold_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && we_i |=> hold_v_q && hold_data_q == $past(wdata_i));
  a_r8_hold_drains: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_v_q && !busy |=> !hold_v_q || $past(busy));
  a_r6_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cen_q && !apply_v |=> $stable(day_q) && $stable(tf_q[0]) && $stable(tf_q[1]) && $stable(tf_q[2]));
endmodule

// File: tb/test_bcd_calendar.sv
module test_bcd_calendar;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       we = 1'b0;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;  // 125 MHz

  bcd_calendar i_bcd_calendar (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // behavioural reference model
  int m_sec, m_min, m_hr, m_day, m_amin, m_ahr, m_aday;
  bit m_cen, m_ien, m_men, m_hen, m_den, m_flag;
  bit p_v; logic [7:0] p_a, p_d;

  function automatic int bin(input int x); return (x >> 4) * 10 + (x & 15); endfunction
  function automatic int bcd(input int x); return ((x / 10) << 4) | (x % 10); endfunction

  task automatic m_apply(input logic [7:0] a, input logic [7:0] d);
    case (a)
      8'h14: begin m_den = d[5]; m_hen = d[4]; m_men = d[3]; m_ien = d[1]; m_cen = d[0];
                   if (d[2]) m_flag = 0; end
      8'h15: m_sec = bin(d & 8'h7f);
      8'h16: m_min = bin(d & 8'h7f);
      8'h17: m_hr  = bin(d & 8'h3f);
      8'h18: m_day = (m_day & 'h7f00) | d;
      8'h19: m_day = (m_day & 'hff) | ((d & 'h7f) << 8);
      8'h1A: m_amin = d & 'h7f;
      8'h1B: m_ahr  = d & 'h3f;
      8'h1C: m_aday = (m_aday & 'h7f00) | d;
      8'h1D: m_aday = (m_aday & 'hff) | ((d & 'h7f) << 8);
      default: ;
    endcase
  endtask

  function automatic logic [7:0] m_read(input logic [7:0] a, input bit bz);
    case (a)
      8'h14: return {bz, 1'b0, m_den, m_hen, m_men, m_flag, m_ien, m_cen};
      8'h15: return 8'(bcd(m_sec));
      8'h16: return 8'(bcd(m_min));
      8'h17: return 8'(bcd(m_hr));
      8'h18: return 8'(m_day & 'hff);
      8'h19: return 8'(m_day >> 8);
      8'h1A: return 8'(m_amin);
      8'h1B: return 8'(m_ahr);
      8'h1C: return 8'(m_aday & 'hff);
      8'h1D: return 8'(m_aday >> 8);
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h14: return "R5";
      8'h15: return "R1";
      8'h16, 8'h17: return "R2";
      8'h18, 8'h19: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", req, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit bz;
    if (!rst_n) begin
      m_sec = 0; m_min = 0; m_hr = 0; m_day = 0; m_amin = 0; m_ahr = 0; m_aday = 0;
      m_cen = 0; m_ien = 0; m_men = 0; m_hen = 0; m_den = 0; m_flag = 0; p_v = 0;
    end else begin
      bz = tick && m_cen;
      if (bz) begin
        if (we) begin p_v = 1; p_a = addr; p_d = wdata; end
        m_sec++;
        if (m_sec == 60) begin
          m_sec = 0; m_min++;
          if (m_min == 60) begin
            m_min = 0; m_hr++;
            if (m_hr == 24) begin m_hr = 0; m_day = (m_day + 1) & 'h7fff; end
          end
          if ((!m_men || m_amin == bcd(m_min)) && (!m_hen || m_ahr == bcd(m_hr)) &&
              (!m_den || m_aday == m_day)) m_flag = 1;
        end
      end else if (p_v) begin
        m_apply(p_a, p_d); p_v = 0;
      end else if (we) m_apply(addr, wdata);
      #2;
      chk(tag_of(addr), rdata, m_read(addr, tick && m_cen));
      chk("R11", irq, m_flag && m_ien);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
    @(negedge clk);
  endtask

  task automatic pulse;
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a; #1;
    chk(req, rdata, exp);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R12 reset state
    rd("R12", 8'h14, 8'h00); rd("R12", 8'h15, 8'h00); rd("R12", 8'h1A, 8'h00);
    chk("R12", irq, 0);
    // R6 ticks ignored while disabled
    repeat (3) pulse();
    rd("R6", 8'h15, 8'h00);
    wr(8'h14, 8'h01);
    wr(8'h15, 8'h58); wr(8'h16, 8'h59); wr(8'h17, 8'h23); wr(8'h18, 8'hFF); wr(8'h19, 8'h7F);
    rd("R4", 8'h19, 8'h7F); rd("R4", 8'h17, 8'h23);
    pulse(); rd("R1", 8'h15, 8'h59);
    pulse();
    rd("R1", 8'h15, 8'h00); rd("R2", 8'h16, 8'h00); rd("R2", 8'h17, 8'h00);
    rd("R3", 8'h18, 8'h00); rd("R3", 8'h19, 8'h00);
    // R3 carry from low byte into high byte
    wr(8'h18, 8'hFF); wr(8'h19, 8'h00); wr(8'h17, 8'h23); wr(8'h16, 8'h59); wr(8'h15, 8'h59);
    pulse();
    rd("R3", 8'h18, 8'h00); rd("R3", 8'h19, 8'h01); rd("R2", 8'h17, 8'h00);
    wr(8'h15, 8'h59); pulse();
    rd("R2", 8'h16, 8'h01); rd("R2", 8'h17, 8'h00);
    // R9 full match
    wr(8'h1A, 8'h02); wr(8'h1B, 8'h00); wr(8'h1C, 8'h00); wr(8'h1D, 8'h01);
    rd("R4", 8'h1D, 8'h01);
    wr(8'h14, 8'h3B); wr(8'h15, 8'h59); pulse();
    rd("R9", 8'h14, 8'h3F); chk("R11", irq, 1);
    // R10 write 0 keeps, write 1 clears
    wr(8'h14, 8'h3B); rd("R10", 8'h14, 8'h3F);
    wr(8'h14, 8'h3F); rd("R10", 8'h14, 8'h3B); chk("R11", irq, 0);
    // R9 mismatch
    wr(8'h15, 8'h59); pulse(); rd("R9", 8'h14, 8'h3B);
    // R9 only minute enabled, hour differs
    wr(8'h1A, 8'h04); wr(8'h14, 8'h0B); wr(8'h1B, 8'h12);
    wr(8'h15, 8'h59); pulse();
    rd("R9", 8'h14, 8'h0F); chk("R11", irq, 1);
    // R11 flag without irq enable
    wr(8'h14, 8'h0D); wr(8'h1A, 8'h05); wr(8'h15, 8'h59); pulse();
    rd("R11", 8'h14, 8'h0D); chk("R11", irq, 0);
    // R9 no field enabled: every minute
    wr(8'h14, 8'h07); rd("R10", 8'h14, 8'h03);
    wr(8'h15, 8'h59); pulse();
    rd("R9", 8'h14, 8'h07); chk("R11", irq, 1);
    // R7 busy visible only during the tick cycle
    @(negedge clk); addr = 8'h14; tick = 1; #1; chk("R7", rdata[7], 1);
    @(negedge clk); tick = 0; #1; chk("R7", rdata[7], 0);
    // R8 tick and write in one cycle (seconds now 01)
    @(negedge clk); tick = 1; we = 1; addr = 8'h15; wdata = 8'h30;
    @(posedge clk); #1; chk("R8", rdata, 8'h02);
    @(negedge clk); tick = 0; we = 0;
    @(posedge clk); #1; chk("R8", rdata, 8'h30);
    @(negedge clk);
    // R10 flag set by tick and clear held behind it
    wr(8'h14, 8'h07); wr(8'h15, 8'h59);
    @(negedge clk); tick = 1; we = 1; addr = 8'h14; wdata = 8'h07;
    @(posedge clk); #1; chk("R9", rdata, 8'h87); chk("R11", irq, 1);
    @(negedge clk); tick = 0; we = 0;
    @(posedge clk); #1; chk("R10", rdata, 8'h03); chk("R11", irq, 0);
    @(negedge clk);
    // R6 disabled again, R7 busy stays low
    wr(8'h14, 8'h00);
    @(negedge clk); addr = 8'h14; tick = 1; #1; chk("R6", rdata, 8'h00);
    @(negedge clk); tick = 0;
    rd("R6", 8'h15, 8'h00);
    // R5 bit 6 and busy ignore writes
    wr(8'h14, 8'hFF); rd("R5", 8'h14, 8'h3B);
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule